// File: doc/BRIEF.md
# IP Address Source Selector

This block settles the device's IPv4 address once reset is released. Two strap pins are read at that moment and choose one of three sources. The first source is a fixed address built in as a parameter. The second is a pair of 16-bit words fetched from a configuration EEPROM through a simple request/acknowledge word port. The third is an address offered by a BootP server.

In BootP mode the block asks the frame builder for a request pulse. It then repeats that request every `RETRY_TICKS` ticks of a slow free-running strobe until a reply is reported. A strap combination that names no source raises a sticky error flag, and the address is never marked valid.

The address output reads zero until the chosen source has delivered. After that, the address and its valid flag hold until the next reset.

Top module: `ip_addr_source`

## Requirements
- R1: With straps {strap_a, strap_b} = 00, the address becomes FIXED_ADDR (default 0xC0A80179, i.e. 192.168.1.121) and ip_valid goes high on the first clock edge after reset release. No EEPROM or BootP activity takes place.
- R2: With straps 01, the block raises ee_req with ee_word_addr = 0x20 and waits for ee_ack. It then raises ee_req with ee_word_addr = 0x22 and waits for ee_ack again. The final address is {word at 0x20, word at 0x22}, with the 0x20 word in bits 31:16.
- R3: ip_valid is low and ip_addr is zero until the selected source has produced its address.
- R4: With straps 11, strap_err goes high on the first edge after reset release. ip_valid never rises and ip_addr stays zero, even if EEPROM acknowledges or BootP replies arrive.
- R5: Once high, strap_err stays high until the next reset.
- R6: With straps 10, a one-cycle bootp_req pulse is issued on the first edge after reset release. A further pulse follows every RETRY_TICKS cycles in which tick is high, for as long as no reply has arrived.
- R7: In BootP mode, a cycle with bootp_valid high loads bootp_addr and sets ip_valid on that edge. No further bootp_req pulses follow.
- R8: The straps are sampled only on the first edge after reset release. Changing them later has no effect on any output.
- R9: Once ip_valid is high, ip_valid and ip_addr hold until reset. Later bootp_valid strobes and ee_ack pulses are ignored.
- R10: While ee_req is high and ee_ack is low, ee_req stays high and ee_word_addr stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a | input | 1 | First strap (upper bit of the strap code) |
| strap_b | input | 1 | Second strap (lower bit of the strap code) |
| ee_req | output | 1 | EEPROM word read request, held until acknowledged |
| ee_word_addr | output | EE_AW | EEPROM word address for the current request |
| ee_ack | input | 1 | One-cycle acknowledge; ee_data is valid in the same cycle |
| ee_data | input | 16 | EEPROM word read data |
| bootp_valid | input | 1 | One-cycle strobe: a BootP reply carrying bootp_addr arrived |
| bootp_addr | input | 32 | Address offered by the BootP server |
| tick | input | 1 | Slow free-running strobe that paces retries |
| ip_addr | output | 32 | Active IPv4 address, zero until valid |
| ip_valid | output | 1 | Address is final |
| bootp_req | output | 1 | One-cycle pulse asking for a BootP request frame |
| strap_err | output | 1 | Straps hold the unused code 11; sticky until reset |

## Verification
The assertions assume that ee_ack arrives only while ee_req is high, as a single-cycle pulse. They also assume that bootp_valid and tick are single-cycle strobes synchronous to clk. The stimulus drives every such pulse on a falling edge for exactly one cycle, and raises ee_ack only after it has seen ee_req. Stray acknowledges and replies are applied only in the invalid-strap and already-valid states, where the requirements say they must be ignored.

// File: rtl/ip_addr_source.sv
module ip_addr_source #(
  parameter int              RETRY_TICKS = 1000,
  parameter logic [31:0]     FIXED_ADDR  = 32'hC0A8_0179,
  parameter int              EE_AW       = 8,
  parameter logic [EE_AW-1:0] EE_HI_ADDR = 8'h20,
  parameter logic [EE_AW-1:0] EE_LO_ADDR = 8'h22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_a,
  input  logic             strap_b,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_word_addr,
  input  logic             ee_ack,
  input  logic [15:0]      ee_data,
  input  logic             bootp_valid,
  input  logic [31:0]      bootp_addr,
  input  logic             tick,
  output logic [31:0]      ip_addr,
  output logic             ip_valid,
  output logic             bootp_req,
  output logic             strap_err
);
  localparam int CW = $clog2(RETRY_TICKS + 1);

  typedef enum logic [2:0] {ST_SAMPLE, ST_EE_HI, ST_EE_LO, ST_BOOT, ST_DONE} st_t;

  st_t           state;
  logic [15:0]   hi_q;
  logic [CW-1:0] cnt;

  assign ee_req       = (state == ST_EE_HI) || (state == ST_EE_LO);
  assign ee_word_addr = (state == ST_EE_LO) ? EE_LO_ADDR : EE_HI_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SAMPLE;
      hi_q      <= '0;
      cnt       <= '0;
      ip_addr   <= '0;
      ip_valid  <= 1'b0;
      bootp_req <= 1'b0;
      strap_err <= 1'b0;
    end else begin
      bootp_req <= 1'b0;
      case (state)
        ST_SAMPLE:
          case ({strap_a, strap_b})
            2'b00: begin
              ip_addr  <= FIXED_ADDR;
              ip_valid <= 1'b1;
              state    <= ST_DONE;
            end
            2'b01: state <= ST_EE_HI;
            2'b10: begin
              bootp_req <= 1'b1;
              cnt       <= '0;
              state     <= ST_BOOT;
            end
            default: begin
              strap_err <= 1'b1;
              state     <= ST_DONE;
            end
          endcase
        ST_EE_HI:
          if (ee_ack) begin
            hi_q  <= ee_data;
            state <= ST_EE_LO;
          end
        ST_EE_LO:
          if (ee_ack) begin
            ip_addr  <= {hi_q, ee_data};
            ip_valid <= 1'b1;
            state    <= ST_DONE;
          end
        ST_BOOT:
          if (bootp_valid) begin
            ip_addr  <= bootp_addr;
            ip_valid <= 1'b1;
            state    <= ST_DONE;
          end else if (tick) begin
            if (cnt == CW'(RETRY_TICKS - 1)) begin
              cnt       <= '0;
              bootp_req <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ip_addr_source_chk.sv
module ip_addr_source_chk #(
  parameter int EE_AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ee_req,
  input logic [EE_AW-1:0] ee_word_addr,
  input logic             ee_ack,
  input logic [31:0]      ip_addr,
  input logic             ip_valid,
  input logic             bootp_req,
  input logic             strap_err
);
  assert_zero_until_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_valid |-> ip_addr == 32'd0);

  assert_err_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strap_err |-> !ip_valid);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strap_err |=> strap_err);

  assert_no_req_when_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid |-> !bootp_req);

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid |=> ip_valid && $stable(ip_addr));

  assert_ee_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_word_addr));
endmodule

bind ip_addr_source ip_addr_source_chk #(.EE_AW(EE_AW)) u_chk (.*);

// File: tb/test_ip_addr_source.sv
module test_ip_addr_source;
  localparam int CLK_PERIOD = 10;
  localparam int RETRY      = 4;
  localparam logic [31:0] FIXED = 32'hC0A8_0179;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_a = 1'b0, strap_b = 1'b0;
  logic        ee_req;
  logic [7:0]  ee_word_addr;
  logic        ee_ack = 1'b0;
  logic [15:0] ee_data = '0;
  logic        bootp_valid = 1'b0;
  logic [31:0] bootp_addr = '0;
  logic        tick = 1'b0;
  logic [31:0] ip_addr;
  logic        ip_valid, bootp_req, strap_err;

  int total = 0, bad = 0, reqs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ip_addr_source #(.RETRY_TICKS(RETRY)) i_ip_addr_source (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .ee_req(ee_req), .ee_word_addr(ee_word_addr), .ee_ack(ee_ack), .ee_data(ee_data),
    .bootp_valid(bootp_valid), .bootp_addr(bootp_addr), .tick(tick),
    .ip_addr(ip_addr), .ip_valid(ip_valid), .bootp_req(bootp_req), .strap_err(strap_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (bootp_req) reqs++;
  endtask

  task automatic start(input logic [1:0] code);
    rst_n = 1'b0;
    {strap_a, strap_b} = code;
    ee_ack = 0; bootp_valid = 0; tick = 0; reqs = 0;
    repeat (2) step();
    check("R3 reset valid", {31'd0, ip_valid}, 32'd0);
    check("R3 reset addr", ip_addr, 32'd0);
    check("R5 reset err", {31'd0, strap_err}, 32'd0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic ee_case(input int lat, input logic [15:0] hi, input logic [15:0] lo);
    start(2'b01);
    check("R2 req hi", {31'd0, ee_req}, 32'd1);
    check("R2 addr hi", {24'd0, ee_word_addr}, 32'h20);
    for (int i = 0; i < lat; i++) begin
      step();
      check("R10 hold hi", {23'd0, ee_req, ee_word_addr}, 32'h120);
      check("R3 not valid", {31'd0, ip_valid}, 32'd0);
    end
    ee_ack = 1; ee_data = hi; step(); ee_ack = 0; ee_data = 16'hDEAD;
    check("R2 addr lo", {23'd0, ee_req, ee_word_addr}, 32'h122);
    check("R3 zero mid", ip_addr, 32'd0);
    for (int i = 0; i < lat; i++) begin
      step();
      check("R10 hold lo", {23'd0, ee_req, ee_word_addr}, 32'h122);
    end
    ee_ack = 1; ee_data = lo; step(); ee_ack = 0;
    check("R2 valid", {31'd0, ip_valid}, 32'd1);
    check("R2 addr", ip_addr, {hi, lo});
    check("R2 req drop", {31'd0, ee_req}, 32'd0);
    ee_ack = 1; ee_data = 16'h1234; step(); ee_ack = 0; step();
    check("R9 ee ignored", ip_addr, {hi, lo});
  endtask

  task automatic boot_case(input int retries, input logic [31:0] offer);
    start(2'b10);
    check("R6 first req", reqs, 1);
    for (int r = 0; r < retries; r++)
      for (int t = 0; t < RETRY; t++) begin
        tick = 1; step(); tick = 0; step();
      end
    check("R6 req count", reqs, 1 + retries);
    check("R3 boot not valid", {31'd0, ip_valid}, 32'd0);
    bootp_valid = 1; bootp_addr = offer; step(); bootp_valid = 0;
    check("R7 valid", {31'd0, ip_valid}, 32'd1);
    check("R7 addr", ip_addr, offer);
    for (int t = 0; t < 2 * RETRY; t++) begin
      tick = 1; step(); tick = 0; step();
    end
    check("R7 no more req", reqs, 1 + retries);
    bootp_valid = 1; bootp_addr = ~offer; step(); bootp_valid = 0;
    check("R9 reply ignored", ip_addr, offer);
  endtask

  initial begin
    for (int sw = 0; sw < 2; sw++) begin
      start(2'b00);
      check("R1 valid", {31'd0, ip_valid}, 32'd1);
      check("R1 addr", ip_addr, FIXED);
      check("R1 no ee", {30'd0, ee_req, bootp_req}, 32'd0);
      if (sw == 1) begin
        {strap_a, strap_b} = 2'b11; repeat (3) step();
        check("R8 strap change err", {31'd0, strap_err}, 32'd0);
        check("R8 strap change addr", ip_addr, FIXED);
      end
    end

    for (int lat = 0; lat < 4; lat++)
      ee_case(lat, 16'h0A0B + 16'(lat * 16'h1111), 16'hF00D - 16'(lat));

    for (int n = 0; n < 4; n++)
      boot_case(n, 32'h0A00_0000 + n * 32'h0101);

    start(2'b11);
    check("R4 err", {31'd0, strap_err}, 32'd1);
    check("R4 no ee req", {31'd0, ee_req}, 32'd0);
    ee_ack = 1; ee_data = 16'h5555; bootp_valid = 1; bootp_addr = 32'h01020304;
    step();
    ee_ack = 0; bootp_valid = 0;
    {strap_a, strap_b} = 2'b00;
    for (int i = 0; i < 20; i++) step();
    check("R4 no valid", {31'd0, ip_valid}, 32'd0);
    check("R4 addr zero", ip_addr, 32'd0);
    check("R5 err held", {31'd0, strap_err}, 32'd1);
    check("R6 no req", reqs, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule